// File: doc/BRIEF.md
# Scalar Float Maximum Unit

This execution unit takes two 128-bit vector operands and produces a 128-bit result in which only the lowest 32-bit lane is computed. That lane receives the larger of two single-precision values. Lanes above it are copied from the first operand. The selection is deliberately asymmetric: the second operand wins when both values are zero of any sign, when either value is a NaN, and when the two values are equal. A signalling NaN in the second operand is returned bit-for-bit, without being quieted.

A per-operation mask can suppress the low-lane write. In merge mode the lane keeps the old destination value, and in zeroing mode it is cleared. Two status flags are reported. The invalid flag is raised for any NaN input, and the denormal flag for any subnormal input. Both flags are computed regardless of the mask.

Operands are captured on an input strobe. The result, the flags and an output strobe appear one clock later and are held until the next strobe.

Top module: `fmax_scalar_unit`

## Requirements
- R1: When both low-lane inputs are zero (exponent and fraction all zero, either sign), the low lane equals the second operand's low lane exactly.
- R2: When the first operand's low lane is a NaN (exponent bits 30:23 all ones, fraction bits 22:0 nonzero), the low lane equals the second operand's low lane, even if that value is an ordinary number.
- R3: When the second operand's low lane is a NaN, the low lane equals it unchanged; a signalling NaN (fraction bit 22 clear) keeps bit 22 clear.
- R4: Otherwise, the first operand is chosen only if it is strictly greater in signed order (positive above negative, infinities at the ends, sign in bit 31); equal values return the second operand.
- R5: Result bits 127:32 equal the first operand's bits 127:32, whatever the mask settings.
- R6: With mask_en_i=1, mask_bit_i=0 and zero_mode_i=0, the low lane equals dest_i[31:0]; with mask_en_i=0 or mask_bit_i=1, the mask has no effect.
- R7: With mask_en_i=1, mask_bit_i=0 and zero_mode_i=1, the low lane is zero.
- R8: invalid_o is 1 exactly when either low-lane input is a NaN, quiet or signalling.
- R9: denorm_o is 1 exactly when either low-lane input is subnormal (exponent zero, fraction nonzero).
- R10: Both flags are computed from the inputs even when the mask suppresses the low-lane write.
- R11: valid_o is 1 in the cycle after a cycle with valid_i=1, and 0 otherwise. The result and flags hold while valid_i=0. Reset clears valid_o, result_o and the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Capture strobe for operands and controls |
| src1_i | input | 128 | First operand; supplies the upper lanes |
| src2_i | input | 128 | Second operand; wins ties and NaNs |
| dest_i | input | 128 | Old destination, used for the merge mask |
| mask_bit_i | input | 1 | Write mask for the low lane |
| mask_en_i | input | 1 | Enables masking |
| zero_mode_i | input | 1 | 1: zero a masked lane, 0: merge |
| valid_o | output | 1 | Result strobe, one cycle after valid_i |
| result_o | output | 128 | Result vector |
| invalid_o | output | 1 | NaN input seen |
| denorm_o | output | 1 | Subnormal input seen |

## Verification
The hardest cases to reach are those where two rules could both apply. Examples are a NaN paired with a zero, a signalling NaN in the second operand, and a flag-raising input under a write mask that hides the computed lane. The directed tasks build each of these from hand-picked encodings. They also use opposite-signed zeros in both orders and equal negative values. Each masked case sets dest_i to a value that differs from both operands, so that merge, zeroing and an unmasked result can be told apart.

// File: rtl/fmax_pkg.sv
package fmax_pkg;
  typedef struct packed {
    logic nan;
    logic zero;
    logic sub;
  } fp_class_t;
endpackage

// File: rtl/fmax_classify.sv
module fmax_classify
  import fmax_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = EXP_W + FRAC_W + 1
) (
  input  logic [W-1:0] val_i,
  output fp_class_t    cls_o
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  assign exp_f  = val_i[FRAC_W +: EXP_W];
  assign frac_f = val_i[FRAC_W-1:0];

  always_comb begin
    cls_o.nan  = (&exp_f) && (|frac_f);
    cls_o.zero = ~(|exp_f) && ~(|frac_f);
    cls_o.sub  = ~(|exp_f) && (|frac_f);
  end
endmodule

// File: rtl/fmax_gt.sv
module fmax_gt #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         gt_o
);
  logic sa, sb;
  logic [W-2:0] ma, mb;
  assign sa = a_i[W-1];
  assign sb = b_i[W-1];
  assign ma = a_i[W-2:0];
  assign mb = b_i[W-2:0];

  // sign-magnitude ordering; zero pairs are resolved upstream
  always_comb begin
    if (sa != sb)  gt_o = sb;
    else if (!sa)  gt_o = ma > mb;
    else           gt_o = ma < mb;
  end
endmodule

// File: rtl/fmax_lane_sel.sv
module fmax_lane_sel
  import fmax_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] dest_i,
  input  fp_class_t    cls_a_i,
  input  fp_class_t    cls_b_i,
  input  logic         gt_i,
  input  logic         mask_en_i,
  input  logic         mask_bit_i,
  input  logic         zero_mode_i,
  output logic [W-1:0] lane_o
);
  logic [W-1:0] max_v;
  logic         take_b;

  assign take_b = (cls_a_i.zero && cls_b_i.zero) || cls_a_i.nan || cls_b_i.nan || !gt_i;
  assign max_v  = take_b ? b_i : a_i;

  always_comb begin
    if (!mask_en_i || mask_bit_i) lane_o = max_v;
    else if (zero_mode_i)         lane_o = '0;
    else                          lane_o = dest_i;
  end
endmodule

// File: rtl/fmax_scalar_unit.sv
module fmax_scalar_unit
  import fmax_pkg::*;
#(
  parameter int VEC_W   = 128,
  parameter int EXP_W   = 8,
  parameter int FRAC_W  = 23,
  localparam int LANE_W = EXP_W + FRAC_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [VEC_W-1:0] src1_i,
  input  logic [VEC_W-1:0] src2_i,
  input  logic [VEC_W-1:0] dest_i,
  input  logic             mask_bit_i,
  input  logic             mask_en_i,
  input  logic             zero_mode_i,
  output logic             valid_o,
  output logic [VEC_W-1:0] result_o,
  output logic             invalid_o,
  output logic             denorm_o
);
  logic [1:0][LANE_W-1:0] opnd;
  fp_class_t [1:0]        cls;
  logic                   gt;
  logic [LANE_W-1:0]      lane;

  assign opnd[0] = src1_i[LANE_W-1:0];
  assign opnd[1] = src2_i[LANE_W-1:0];

  for (genvar g = 0; g < 2; g++) begin : g_cls
    fmax_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .val_i (opnd[g]),
      .cls_o (cls[g])
    );
  end

  fmax_gt #(.W(LANE_W)) u_gt (
    .a_i  (opnd[0]),
    .b_i  (opnd[1]),
    .gt_o (gt)
  );

  fmax_lane_sel #(.W(LANE_W)) u_sel (
    .a_i         (opnd[0]),
    .b_i         (opnd[1]),
    .dest_i      (dest_i[LANE_W-1:0]),
    .cls_a_i     (cls[0]),
    .cls_b_i     (cls[1]),
    .gt_i        (gt),
    .mask_en_i   (mask_en_i),
    .mask_bit_i  (mask_bit_i),
    .zero_mode_i (zero_mode_i),
    .lane_o      (lane)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      result_o  <= '0;
      invalid_o <= 1'b0;
      denorm_o  <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o  <= {src1_i[VEC_W-1:LANE_W], lane};
        invalid_o <= cls[0].nan | cls[1].nan;
        denorm_o  <= cls[0].sub | cls[1].sub;
      end
    end
  end
endmodule

// File: rtl/fmax_sva.sv
module fmax_sva #(
  parameter int VEC_W  = 128,
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int LANE_W = EXP_W + FRAC_W + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [VEC_W-1:0] src1_i,
  input logic [VEC_W-1:0] src2_i,
  input logic [VEC_W-1:0] dest_i,
  input logic             mask_bit_i,
  input logic             mask_en_i,
  input logic             zero_mode_i,
  input logic             valid_o,
  input logic [VEC_W-1:0] result_o,
  input logic             invalid_o,
  input logic             denorm_o
);
  logic b_nan, a_nan, unmasked;
  assign a_nan = (&src1_i[FRAC_W +: EXP_W]) && (|src1_i[FRAC_W-1:0]);
  assign b_nan = (&src2_i[FRAC_W +: EXP_W]) && (|src2_i[FRAC_W-1:0]);
  assign unmasked = !mask_en_i || mask_bit_i;

  assert_valid_follow_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i));
  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o) && $stable(invalid_o) && $stable(denorm_o));
  assert_upper_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> result_o[VEC_W-1:LANE_W] == $past(src1_i[VEC_W-1:LANE_W]));
  assert_nan_pass_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && unmasked && b_nan |=> result_o[LANE_W-1:0] == $past(src2_i[LANE_W-1:0]));
  assert_nan_a_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && unmasked && a_nan |=> result_o[LANE_W-1:0] == $past(src2_i[LANE_W-1:0]));
  assert_merge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && mask_en_i && !mask_bit_i && !zero_mode_i |=> result_o[LANE_W-1:0] == $past(dest_i[LANE_W-1:0]));
  assert_zeroing_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && mask_en_i && !mask_bit_i && zero_mode_i |=> result_o[LANE_W-1:0] == '0);
  assert_invalid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> invalid_o == $past(a_nan || b_nan));
endmodule

bind fmax_scalar_unit fmax_sva #(.VEC_W(VEC_W), .EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_sva (.*);

// File: tb/sim_fmax_scalar_unit.sv
`timescale 1ns/1ps
module sim_fmax_scalar_unit;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [127:0] src1_i = '0, src2_i = '0, dest_i = '0;
  logic         mask_bit_i = 1'b0, mask_en_i = 1'b0, zero_mode_i = 1'b0;
  logic         valid_o, invalid_o, denorm_o;
  logic [127:0] result_o;
  int checks = 0, failures = 0;

  always #2.5 clk_i = ~clk_i;

  fmax_scalar_unit u0 (.*);

  localparam logic [31:0] P1 = 32'h3f800000, P2 = 32'h40000000, N1 = 32'hbf800000,
    N2 = 32'hc0000000, PZ = 32'h0, NZ = 32'h80000000, QN = 32'h7fc00000,
    SN = 32'h7f800001, PINF = 32'h7f800000, NINF = 32'hff800000,
    DN = 32'h00000001, NDN = 32'h80000005;
  localparam logic [95:0] UPA = 96'hdeadbeef_01234567_89abcdef;
  localparam logic [31:0] DST = 32'h12345678;

  function automatic bit is_nan(logic [31:0] x);
    return (x[30:23] == 8'hff) && (x[22:0] != 0);
  endfunction
  function automatic bit is_sub(logic [31:0] x);
    return (x[30:23] == 0) && (x[22:0] != 0);
  endfunction
  // ordered key: unsigned compare gives signed float order
  function automatic logic [31:0] okey(logic [31:0] x);
    return x[31] ? ~x : (x | 32'h80000000);
  endfunction
  function automatic logic [31:0] ref_max(logic [31:0] a, logic [31:0] b);
    if (a[30:0] == 0 && b[30:0] == 0) return b;
    if (is_nan(a) || is_nan(b)) return b;
    return (okey(a) > okey(b)) ? a : b;
  endfunction

  task automatic check(string req, logic [127:0] got, logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic issue(logic [31:0] a, logic [31:0] b, bit men, bit mbit, bit zm);
    @(negedge clk_i);
    src1_i = {UPA, a}; src2_i = {~UPA, b}; dest_i = {64'h0, 32'hcafe, DST};
    mask_en_i = men; mask_bit_i = mbit; zero_mode_i = zm; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic run_max(string req, logic [31:0] a, logic [31:0] b);
    issue(a, b, 1'b0, 1'b0, 1'b0);
    check(req, result_o, {UPA, ref_max(a, b)});
    check({req, "_R8_flag"}, invalid_o, is_nan(a) || is_nan(b));
    check({req, "_R9_flag"}, denorm_o, is_sub(a) || is_sub(b));
  endtask

  task automatic t_reset();
    check("R11_reset_valid", valid_o, 0);
    check("R11_reset_result", result_o, 0);
    check("R11_reset_flags", {invalid_o, denorm_o}, 0);
  endtask

  task automatic t_zeros();
    run_max("R1_pz_nz", PZ, NZ);
    run_max("R1_nz_pz", NZ, PZ);
  endtask

  task automatic t_nans();
    run_max("R2_qnan_a", QN, P1);
    run_max("R2_snan_a_zero_b", SN, PZ);
    run_max("R3_snan_b", P2, SN);
    check("R3_snan_quiet_bit", result_o[22], 0);
    run_max("R3_qnan_b", NINF, QN);
  endtask

  task automatic t_order();
    run_max("R4_pos_gt", P2, P1);
    run_max("R4_pos_lt", P1, P2);
    run_max("R4_neg", N1, N2);
    run_max("R4_neg_rev", N2, N1);
    run_max("R4_mixed", N1, P1);
    run_max("R4_mixed_rev", P1, N1);
    run_max("R4_equal", N2, N2);
    run_max("R4_inf", PINF, P2);
    run_max("R4_ninf", NINF, N2);
    run_max("R9_denorm", DN, NDN);
    run_max("R9_denorm_vs_zero", NZ, DN);
  endtask

  task automatic t_mask();
    issue(P2, P1, 1'b1, 1'b0, 1'b0);
    check("R6_merge", result_o, {UPA, DST});
    issue(P2, P1, 1'b1, 1'b0, 1'b1);
    check("R7_zeroing", result_o, {UPA, 32'h0});
    issue(P2, P1, 1'b1, 1'b1, 1'b1);
    check("R6_mask_bit_set", result_o, {UPA, P2});
    issue(P2, P1, 1'b0, 1'b0, 1'b1);
    check("R6_mask_off", result_o, {UPA, P2});
    issue(QN, DN, 1'b1, 1'b0, 1'b1);
    check("R10_flags_zeroed", {invalid_o, denorm_o}, 2'b11);
    check("R10_lane_zeroed", result_o, {UPA, 32'h0});
    issue(SN, NDN, 1'b1, 1'b0, 1'b0);
    check("R10_flags_merged", {invalid_o, denorm_o}, 2'b11);
    check("R5_upper_masked", result_o[127:32], UPA);
  endtask

  task automatic t_hold();
    issue(P1, N1, 1'b0, 1'b0, 1'b0);
    check("R11_valid_high", valid_o, 1);
    @(negedge clk_i);
    check("R11_valid_low", valid_o, 0);
    src1_i = {~UPA, P2}; src2_i = {UPA, QN};
    @(negedge clk_i);
    @(negedge clk_i);
    check("R11_hold_result", result_o, {UPA, P1});
    check("R11_hold_flags", {invalid_o, denorm_o}, 2'b00);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_zeros();
    t_nans();
    t_order();
    t_mask();
    t_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule